// File: doc/BRIEF.md
# Rail Dependency Gating and Power-Good Aggregator

This block sits between a power-mode sequencer and the individual regulators of a display power supply. The sequencer hands it a request for the two internal converters and one enable request for each output rail. The block passes each request through to the regulator only once the supply that rail depends on reports power-good. The inverting converter comes first. The positive boost follows it. The negative LDO, the common-electrode driver and both charge pumps hang off the boost, and the positive LDO hangs off the negative LDO.

Each of the four monitored output rails has an undervoltage flag. An undervoltage on an enabled rail latches a per-rail fault that turns that rail off, along with any rail below it in the tree. The converters and the unrelated rails keep running. A latched fault clears only when the sequencer drops that rail's request, so the rail needs a full low-then-high request cycle before it comes back. Thermal, input-undervoltage and converter-undervoltage conditions are chip-wide faults. They are reported to the sequencer as one registered request, and the sequencer then runs the ordered shutdown. An active-low, registered power-good output is released only when all four monitored rails are enabled, report good, and carry no fault.

Top module: `rail_gate_pg`

## Requirements
- R1: After reset, every enable output is 0, `pg_n` is 1 and `gfault` is 0.
- R2: `dcdc2_en` equals `conv_req` one clock later. `dcdc1_en` equals `conv_req & dcdc2_pg` one clock later.
- R3: `rail_en` bits 0 (VNEG), 1 (VEE), 3 (VDDH) and 4 (VCOM) are 1 one clock after their request is high while `dcdc1_pg` is high. A low `dcdc1_pg` holds them at 0.
- R4: `rail_en` bit 2 (VPOS) also requires `rail_pg` bit 0 (VNEG good) to be high in the previous cycle.
- R5: When `rail_uv[i]` is high while `rail_en[i]` is 1 (i in 0..3), `rail_en[i]` goes to 0 on the next clock. The converter enables and the other independent rails are unaffected.
- R6: An undervoltage on VNEG (bit 0) also latches a fault on VPOS (bit 2), so both drop on the same clock.
- R7: A rail turned off by a fault stays off after its undervoltage clears and its request stays high. The fault clears when the request is seen low. The rail returns one clock after the request rises again.
- R8: `rail_uv[i]` is ignored while `rail_en[i]` is 0. A later request brings the rail up normally.
- R9: Any bit of `glb_src` (0 thermal, 1 input UVLO, 2 boost UV, 3 inverting UV) sets `gfault` and `pg_n` high on the next clock. Both follow the source back when it clears.
- R10: `pg_n` is 0 only when, in the previous cycle, `rail_en[3:0]` were all 1, `rail_pg[3:0]` were all 1, no fault was latched or being latched, and no global source was active. VCOM (bit 4) takes no part.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_req | input | 1 | Sequencer request to run the converters |
| rail_req | input | 5 | Per-rail enable request: 0 VNEG, 1 VEE, 2 VPOS, 3 VDDH, 4 VCOM |
| dcdc2_pg | input | 1 | Inverting converter in regulation |
| dcdc1_pg | input | 1 | Positive boost in regulation |
| rail_pg | input | 4 | Monitored rails in regulation, bits as in rail_req |
| rail_uv | input | 4 | Monitored rails undervoltage, bits as in rail_req |
| glb_src | input | 4 | Chip-wide fault sources: 0 thermal, 1 UVLO, 2 boost UV, 3 inverting UV |
| dcdc2_en | output | 1 | Gated enable to the inverting converter |
| dcdc1_en | output | 1 | Gated enable to the positive boost |
| rail_en | output | 5 | Gated enables to the output rails |
| pg_n | output | 1 | Power-good, 0 = all rails good (drives an open-drain pull-down) |
| gfault | output | 1 | Chip-wide fault request to the sequencer |

## Verification
The dependency tree is tried by raising requests while one parent good signal at a time is held low. Each case separates a gate wired to the wrong parent from a correct one. Local undervoltage is injected on a leaf rail (VEE) and on a parent rail (VNEG). This separates dropping one rail from propagating to the child, and it shows that each rail needs its own request toggle to return. Undervoltage on a disabled rail, each global source in turn, and an unrequested VCOM against an unrequested monitored rail show what the power-good output may and may not depend on.

// File: rtl/rgp_pkg.sv
package rgp_pkg;
  localparam int NUM_RAILS = 5;
  localparam int NUM_MON   = 4;
  localparam int IDX_VNEG  = 0;
  localparam int IDX_VEE   = 1;
  localparam int IDX_VPOS  = 2;
  localparam int IDX_VDDH  = 3;
  localparam int IDX_VCOM  = 4;
endpackage

// File: rtl/rgp_fault_latch.sv
module rgp_fault_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] flt_q,
  output logic [N-1:0] flt_nx
);
  logic [N-1:0] req_q;
  logic [N-1:0] req_fall;

  assign req_fall = req_q & ~req_i;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_flag
      // a falling request takes priority: the rail is going off anyway
      always_comb begin
        if (req_fall[g]) flt_nx[g] = 1'b0;
        else             flt_nx[g] = flt_q[g] | set_i[g];
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          flt_q[g] <= 1'b0;
          req_q[g] <= 1'b0;
        end else begin
          flt_q[g] <= flt_nx[g];
          req_q[g] <= req_i[g];
        end
      end

      // R7: a latched flag survives until the request has been seen low
      a_r7_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (flt_q[g] && req_i[g]) |=> flt_q[g]);
    end
  endgenerate
endmodule

// File: rtl/rgp_enable_gate.sv
module rgp_enable_gate
  import rgp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 conv_req,
  input  logic                 dcdc2_pg,
  input  logic                 dcdc1_pg,
  input  logic [NUM_RAILS-1:0] rail_req,
  input  logic [NUM_RAILS-1:0] parent_pg,
  input  logic [NUM_RAILS-1:0] blocked,
  output logic                 dcdc2_en,
  output logic                 dcdc1_en,
  output logic [NUM_RAILS-1:0] rail_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dcdc2_en <= 1'b0;
      dcdc1_en <= 1'b0;
    end else begin
      dcdc2_en <= conv_req;
      dcdc1_en <= conv_req & dcdc2_pg;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_RAILS; g++) begin : g_rail
      always_ff @(posedge clk) begin
        if (rst) rail_en[g] <= 1'b0;
        else     rail_en[g] <= rail_req[g] & dcdc1_pg & parent_pg[g] & ~blocked[g];
      end

      // R3: no output rail is enabled without the boost being good
      a_r3_boost_gate: assert property (@(posedge clk) disable iff (rst)
        rail_en[g] |-> $past(dcdc1_pg));
    end
  endgenerate

  // R2: the boost waits for the inverting converter
  a_r2_dcdc1_gate: assert property (@(posedge clk) disable iff (rst)
    dcdc1_en |-> $past(dcdc2_pg));
  // R2: converter request reaches the inverting converter in one cycle
  a_r2_dcdc2_follow: assert property (@(posedge clk) disable iff (rst)
    conv_req |=> dcdc2_en);
endmodule

// File: rtl/rgp_pg_agg.sv
module rgp_pg_agg #(
  parameter int NMON = 4,
  parameter int NGLB = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NMON-1:0] en_q,
  input  logic [NMON-1:0] rail_pg,
  input  logic [NMON-1:0] flt_nx,
  input  logic [NGLB-1:0] glb_src,
  output logic            pg_n,
  output logic            gfault
);
  logic all_good;
  logic glb_any;

  assign glb_any  = |glb_src;
  assign all_good = (&en_q) & (&rail_pg) & ~(|flt_nx) & ~glb_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_n   <= 1'b1;
      gfault <= 1'b0;
    end else begin
      pg_n   <= ~all_good;
      gfault <= glb_any;
    end
  end

  // R9: any chip-wide source is reported next cycle and holds power-good off
  a_r9_gfault_raise: assert property (@(posedge clk) disable iff (rst)
    (|glb_src) |=> (gfault && pg_n));
  // R10: released power-good implies every monitored rail was on and good
  a_r10_pg_release: assert property (@(posedge clk) disable iff (rst)
    !pg_n |-> $past((&en_q) && (&rail_pg)));
endmodule

// File: rtl/rail_gate_pg.sv
module rail_gate_pg
  import rgp_pkg::*;
#(
  parameter int NUM_GLOBAL = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  conv_req,
  input  logic [NUM_RAILS-1:0]  rail_req,
  input  logic                  dcdc2_pg,
  input  logic                  dcdc1_pg,
  input  logic [NUM_MON-1:0]    rail_pg,
  input  logic [NUM_MON-1:0]    rail_uv,
  input  logic [NUM_GLOBAL-1:0] glb_src,
  output logic                  dcdc2_en,
  output logic                  dcdc1_en,
  output logic [NUM_RAILS-1:0]  rail_en,
  output logic                  pg_n,
  output logic                  gfault
);
  logic [NUM_MON-1:0]   uv_hit;
  logic [NUM_MON-1:0]   flt_set;
  logic [NUM_MON-1:0]   flt_q;
  logic [NUM_MON-1:0]   flt_nx;
  logic [NUM_RAILS-1:0] parent_pg;
  logic [NUM_RAILS-1:0] blocked;

  // undervoltage only counts on a rail that is actually enabled
  assign uv_hit = rail_uv & rail_en[NUM_MON-1:0];

  // a fault on the negative LDO also takes down the positive LDO beneath it
  always_comb begin
    flt_set           = uv_hit;
    flt_set[IDX_VPOS] = uv_hit[IDX_VPOS] | uv_hit[IDX_VNEG];
  end

  rgp_fault_latch #(.N(NUM_MON)) i_flags (
    .clk   (clk),
    .rst   (rst),
    .set_i (flt_set),
    .req_i (rail_req[NUM_MON-1:0]),
    .flt_q (flt_q),
    .flt_nx(flt_nx)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_RAILS; g++) begin : g_tree
      if (g == IDX_VPOS) begin : g_child
        assign parent_pg[g] = rail_pg[IDX_VNEG];
      end else begin : g_root
        assign parent_pg[g] = 1'b1;
      end
      if (g < NUM_MON) begin : g_mon
        assign blocked[g] = flt_nx[g];

        // R5: an undervoltage on an enabled rail switches it off next cycle
        a_r5_uv_drop: assert property (@(posedge clk) disable iff (rst)
          (rail_en[g] && rail_uv[g]) |=> !rail_en[g]);
      end else begin : g_unmon
        assign blocked[g] = 1'b0;
      end
    end
  endgenerate

  rgp_enable_gate i_gate (
    .clk      (clk),
    .rst      (rst),
    .conv_req (conv_req),
    .dcdc2_pg (dcdc2_pg),
    .dcdc1_pg (dcdc1_pg),
    .rail_req (rail_req),
    .parent_pg(parent_pg),
    .blocked  (blocked),
    .dcdc2_en (dcdc2_en),
    .dcdc1_en (dcdc1_en),
    .rail_en  (rail_en)
  );

  rgp_pg_agg #(.NMON(NUM_MON), .NGLB(NUM_GLOBAL)) i_pg (
    .clk    (clk),
    .rst    (rst),
    .en_q   (rail_en[NUM_MON-1:0]),
    .rail_pg(rail_pg),
    .flt_nx (flt_nx),
    .glb_src(glb_src),
    .pg_n   (pg_n),
    .gfault (gfault)
  );

  // R4: positive LDO only comes up behind a good negative LDO
  a_r4_vpos_gate: assert property (@(posedge clk) disable iff (rst)
    rail_en[IDX_VPOS] |-> $past(rail_pg[IDX_VNEG]));
  // R6: a negative LDO undervoltage drops the positive LDO as well
  a_r6_vneg_child: assert property (@(posedge clk) disable iff (rst)
    (rail_en[IDX_VNEG] && rail_uv[IDX_VNEG]) |=> !rail_en[IDX_VPOS]);
  // R5: a local undervoltage leaves the converters running
  a_r5_conv_stay: assert property (@(posedge clk) disable iff (rst)
    ((|uv_hit) && conv_req && dcdc2_pg) |=> (dcdc2_en && dcdc1_en));
endmodule

// File: tb/test_rail_gate_pg.sv
module test_rail_gate_pg;
  logic       clk = 1'b0;
  logic       rst;
  logic       conv_req;
  logic [4:0] rail_req;
  logic       dcdc2_pg, dcdc1_pg;
  logic [3:0] rail_pg, rail_uv, glb_src;
  logic       dcdc2_en, dcdc1_en, pg_n, gfault;
  logic [4:0] rail_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rail_gate_pg i_rail_gate_pg (
    .clk(clk), .rst(rst), .conv_req(conv_req), .rail_req(rail_req),
    .dcdc2_pg(dcdc2_pg), .dcdc1_pg(dcdc1_pg), .rail_pg(rail_pg),
    .rail_uv(rail_uv), .glb_src(glb_src), .dcdc2_en(dcdc2_en),
    .dcdc1_en(dcdc1_en), .rail_en(rail_en), .pg_n(pg_n), .gfault(gfault)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    conv_req = 0; rail_req = '0; dcdc2_pg = 0; dcdc1_pg = 0;
    rail_pg = '0; rail_uv = '0; glb_src = '0;
  endtask

  task automatic all_up();
    conv_req = 1; dcdc2_pg = 1; dcdc1_pg = 1; rail_pg = 4'hF; rail_req = 5'h1F;
    tick(2);
  endtask

  task automatic t_reset();
    idle_inputs();
    conv_req = 1; rail_req = 5'h1F; dcdc2_pg = 1; dcdc1_pg = 1; rail_pg = 4'hF;
    glb_src = 4'h1;
    rst = 1;
    tick(3);
    check("R1 converters off in reset", {dcdc2_en, dcdc1_en}, 0);
    check("R1 rails off in reset", rail_en, 0);
    check("R1 pg_n high in reset", pg_n, 1);
    check("R1 gfault low in reset", gfault, 0);
    idle_inputs();
    rst = 0;
    tick(1);
  endtask

  task automatic t_tree();
    idle_inputs();
    conv_req = 1; rail_req = 5'h1F; rail_pg = 4'hF;
    tick(1);
    check("R2 dcdc2_en follows request", dcdc2_en, 1);
    check("R2 dcdc1 held without dcdc2_pg", dcdc1_en, 0);
    check("R3 rails held without dcdc1_pg", rail_en, 0);
    dcdc2_pg = 1;
    tick(1);
    check("R2 dcdc1 up after dcdc2_pg", dcdc1_en, 1);
    dcdc1_pg = 1; rail_pg = 4'h0;
    tick(1);
    check("R4 VPOS held without VNEG good", rail_en, 5'b11011);
    rail_pg = 4'hF;
    tick(1);
    check("R4 VPOS up after VNEG good", rail_en, 5'h1F);
    check("R10 pg needs prior-cycle enables", pg_n, 1);
    tick(1);
    check("R10 pg released all good", pg_n, 0);
    dcdc1_pg = 0;
    tick(1);
    check("R3 boost loss drops rails", rail_en, 0);
    check("R2 converters stay on", {dcdc2_en, dcdc1_en}, 2'b11);
    idle_inputs();
    tick(2);
  endtask

  task automatic t_leaf_uv();
    all_up();
    rail_uv[1] = 1;
    tick(1);
    check("R5 VEE dropped", rail_en, 5'b11101);
    check("R5 converters stay", {dcdc2_en, dcdc1_en}, 2'b11);
    check("R10 pg_n high with fault", pg_n, 1);
    rail_uv[1] = 0;
    tick(2);
    check("R7 VEE stays off after uv clears", rail_en[1], 0);
    check("R7 pg_n stays high", pg_n, 1);
    rail_req[1] = 0;
    tick(1);
    rail_req[1] = 1;
    tick(1);
    check("R7 VEE back after toggle", rail_en[1], 1);
    tick(1);
    check("R7 pg_n released again", pg_n, 0);
    idle_inputs();
    tick(2);
  endtask

  task automatic t_parent_uv();
    all_up();
    rail_uv[0] = 1;
    tick(1);
    check("R6 VNEG and VPOS dropped", rail_en, 5'b11010);
    rail_uv[0] = 0;
    rail_req[0] = 0;
    tick(1);
    rail_req[0] = 1;
    tick(2);
    check("R6 VPOS needs own toggle", rail_en, 5'b11011);
    rail_req[2] = 0;
    tick(1);
    rail_req[2] = 1;
    tick(1);
    check("R7 VPOS back after toggle", rail_en, 5'h1F);
    idle_inputs();
    tick(2);
  endtask

  task automatic t_uv_disabled();
    all_up();
    rail_req[3] = 0;
    tick(1);
    rail_uv[3] = 1;
    tick(1);
    check("R8 other rails untouched", rail_en, 5'b10111);
    rail_uv[3] = 0;
    rail_req[3] = 1;
    tick(1);
    check("R8 VDDH comes up normally", rail_en[3], 1);
    tick(1);
    check("R8 pg released", pg_n, 0);
    idle_inputs();
    tick(2);
  endtask

  task automatic t_global();
    all_up();
    tick(1);
    for (int k = 0; k < 4; k++) begin
      glb_src = 4'(1 << k);
      tick(1);
      check("R9 gfault raised", gfault, 1);
      check("R9 pg_n high on global", pg_n, 1);
      glb_src = 0;
      tick(1);
      check("R9 gfault cleared", gfault, 0);
      check("R9 pg_n back low", pg_n, 0);
    end
    idle_inputs();
    tick(2);
  endtask

  task automatic t_pg_members();
    all_up();
    rail_req[4] = 0;
    tick(2);
    check("R10 VCOM not part of pg", pg_n, 0);
    rail_req[4] = 1; rail_req[1] = 0;
    tick(2);
    check("R10 missing VEE holds pg off", pg_n, 1);
    rail_req[1] = 1; rail_pg[3] = 0;
    tick(2);
    check("R10 VDDH not good holds pg off", pg_n, 1);
    idle_inputs();
    tick(2);
  endtask

  initial begin
    fork
      begin
        rst = 1;
        idle_inputs();
        t_reset();
        t_tree();
        t_leaf_uv();
        t_parent_uv();
        t_uv_disabled();
        t_global();
        t_pg_members();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule